// File: doc/BRIEF.md
# Channel/Gain Scan Sequencer

This block paces an analog acquisition front end. It walks a host-loaded scan list in which each entry names an input channel and a gain code, and for every entry it opens a fixed time slot: it drives the multiplexer and gain selection, fires a one-cycle convert strobe toward the converter, and pushes a tagged record describing the slot. Digital port samples and counter samples are taken in the spare cycles of a slot, so they never lengthen the analog sequence. They are taken either on the first slot of a scan only or, for digital ports, on every slot.

A scan covers the list entries from index 0 to a programmed last index. When the scan ends, the next one either starts at once, starts after a programmed gap counted in clock ticks, or, in external-clock mode, waits for the next rising edge of an asynchronous scan clock. An edge that arrives while a scan is in progress is dropped and raises a sticky overrun flag. A digital-only mode shortens slots to 4 ticks and suppresses conversion. Every record carries a 2-bit type tag so a consumer can split the mixed stream.

Top module: `scan_sequencer`

## Requirements
- R1: An entry written at list address a (with `wr_en`) is presented on `mux_chan`/`mux_gain` during slot a, and the analog record of that slot carries data {a[8:0], chan[3:0], gain[2:0]} (index in bits 15:7, channel in bits 6:3, gain in bits 2:0).
- R2: In analog mode each slot lasts 48 clock cycles; `adc_conv` is a one-cycle pulse in the first cycle of every slot, and one analog record is pushed per slot.
- R3: A scan covers entries 0 to `last_idx`; with internal pacing the next scan begins `scan_gap` cycles after the last slot ends, so the scan period is (last_idx+1) x slot length + scan_gap.
- R4: With `per_slot_dig` low, `dig_strobe` equals `port_en` in the second cycle of the first slot of each scan only, and one digital record (tag 1, data = slot index) is pushed then.
- R5: Counters are sampled once per scan in every mode: `cnt_strobe` equals `cnt_en` in the third cycle of the first slot with one counter record (tag 2); with `per_slot_dig` high, digital sampling happens in the second cycle of every slot.
- R6: Digital and counter sampling never changes the scan period.
- R7: With `dig_only` high, slots last 4 cycles, `adc_conv` stays low and no analog records are pushed.
- R8: With `ext_mode` high, no scan starts until a rising edge of `ext_clk`; each edge seen while waiting starts exactly one scan, whose first convert strobe appears on the third clock edge after `ext_clk` rises.
- R9: An `ext_clk` rising edge while a scan is running sets `overrun`, starts no extra scan, and the flag stays set until `run` is raised again from idle.
- R10: Record tags are 0 analog, 1 digital, 2 counter, 3 status; at most one record per cycle; a status record is pushed in the fourth cycle of the last slot with data {overrun, number of scans completed since start, counting this one, in bits 14:0}.
- R11: When `run` falls, the scan in progress completes (including its status record) and then no strobes or records are produced.
- R12: During and right after reset, `adc_conv`, `dig_strobe`, `cnt_strobe`, `rec_valid`, `overrun` and `mux_chan` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock, one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one scan-list entry |
| wr_addr | input | 9 | Scan-list address to write |
| wr_chan | input | 4 | Channel number of the written entry |
| wr_gain | input | 3 | Gain code of the written entry |
| run | input | 1 | Level: start scanning / stop at scan end |
| last_idx | input | 9 | Index of the final entry of a scan |
| scan_gap | input | 32 | Ticks between scans under internal pacing |
| per_slot_dig | input | 1 | Sample digital ports on every slot |
| dig_only | input | 1 | 4-tick slots without conversion |
| ext_mode | input | 1 | Pace scans from ext_clk edges |
| ext_clk | input | 1 | Asynchronous external scan clock |
| port_en | input | 3 | Enabled digital ports |
| cnt_en | input | 4 | Enabled counters |
| mux_chan | output | 4 | Channel select for the current slot |
| mux_gain | output | 3 | Gain select for the current slot |
| adc_conv | output | 1 | Convert strobe, first cycle of a slot |
| dig_strobe | output | 3 | Per-port digital sample strobe |
| cnt_strobe | output | 4 | Per-counter sample strobe |
| rec_valid | output | 1 | Record push toward the FIFO |
| rec_tag | output | 2 | Record type tag |
| rec_data | output | 16 | Record payload |
| overrun | output | 1 | Sticky external-edge overrun flag |

## Verification
The embedded properties take for granted that the configuration inputs (`last_idx`, `scan_gap`, the mode bits and the enable masks) stay constant while `run` is high or a scan is still finishing, and that the list is written only while the sequencer is idle. The stimulus changes configuration and writes the list only after `run` has been low long enough for the longest programmed scan to drain, and it holds each `ext_clk` level for many cycles so the synchronizer sees clean edges.

// File: rtl/seq_pkg.sv
// Shared types of the scan sequencer: record tags and control states.
// Assumes nothing beyond a 2-bit tag field on the record stream.
package seq_pkg;
    typedef enum logic [1:0] {
        TAG_ANA = 2'd0,
        TAG_DIG = 2'd1,
        TAG_CNT = 2'd2,
        TAG_STA = 2'd3
    } rec_tag_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2,
        ST_WAIT = 2'd3
    } seq_state_t;
endpackage

// File: rtl/seq_list_ram.sv
// Scan-list storage: one write port for the host, one asynchronous read port
// addressed by the slot index. Assumes writes happen while the engine is idle.
module seq_list_ram #(
    parameter int DEPTH = 512,
    parameter int ENT_W = 7,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [ENT_W-1:0] rd_data
);
    logic [ENT_W-1:0] mem [DEPTH];

    // Store one entry per host write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the entry of the current slot.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/seq_edge_sync.sv
// Brings the asynchronous external scan clock into the clock domain and
// flags each rising edge for exactly one cycle. Assumes the input holds each
// level for at least two clock cycles.
module seq_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    // Two-stage synchronizer plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;

    assert_single_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/seq_slot_ctrl.sv
// Slot and scan timing: tick counter inside a slot, slot index inside a scan,
// inter-scan gap, external-edge waiting and overrun detection.
// Assumes configuration inputs are stable while running.
module seq_slot_ctrl
    import seq_pkg::*;
#(
    parameter int IDX_W      = 9,
    parameter int GAP_W      = 32,
    parameter int SLOT_TICKS = 48,
    parameter int DIG_TICKS  = 4,
    localparam int TICK_W    = $clog2(SLOT_TICKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ext_mode,
    input  logic              dig_only,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [GAP_W-1:0]  scan_gap,
    input  logic              ext_rise,
    output seq_state_t        state,
    output logic [IDX_W-1:0]  idx,
    output logic [TICK_W-1:0] tick,
    output logic              overrun
);
    logic [GAP_W-1:0]  gap_cnt;
    logic [TICK_W-1:0] tick_last;
    logic              slot_end;
    logic              scan_end;

    // Last tick of a slot depends on the slot flavour.
    assign tick_last = dig_only ? TICK_W'(DIG_TICKS - 1) : TICK_W'(SLOT_TICKS - 1);
    assign slot_end  = (tick == tick_last);
    assign scan_end  = slot_end && (idx == last_idx);

    // Main sequencing state machine with slot, index and gap counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            tick    <= '0;
            gap_cnt <= '0;
            overrun <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    idx  <= '0;
                    tick <= '0;
                    if (run) begin
                        overrun <= 1'b0;
                        state   <= ext_mode ? ST_WAIT : ST_RUN;
                    end
                end
                ST_WAIT: begin
                    if (!run)          state <= ST_IDLE;
                    else if (ext_rise) state <= ST_RUN;
                end
                ST_GAP: begin
                    if (!run) begin
                        state <= ST_IDLE;
                    end else if (gap_cnt == scan_gap - GAP_W'(1)) begin
                        state   <= ST_RUN;
                        gap_cnt <= '0;
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                default: begin
                    if (ext_mode && ext_rise) overrun <= 1'b1;
                    if (!slot_end) begin
                        tick <= tick + TICK_W'(1);
                    end else begin
                        tick <= '0;
                        if (scan_end) begin
                            idx     <= '0;
                            gap_cnt <= '0;
                            if (!run)                  state <= ST_IDLE;
                            else if (ext_mode)         state <= ST_WAIT;
                            else if (scan_gap != '0)   state <= ST_GAP;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    assert_gap_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (scan_gap != '0));
    assert_overrun_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(state == ST_IDLE && run)) |=> overrun);
    assert_tick_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick <= TICK_W'(SLOT_TICKS - 1)));
endmodule

// File: rtl/scan_sequencer.sv
// Top of the channel/gain scan sequencer. Decodes slot timing into the
// convert strobe, digital and counter sample strobes and tagged records.
// Assumes configuration is static while running and SLOT_TICKS > DIG_TICKS >= 4.
module scan_sequencer
    import seq_pkg::*;
#(
    parameter int LIST_DEPTH = 512,
    parameter int CH_W       = 4,
    parameter int GAIN_W     = 3,
    parameter int SLOT_TICKS = 48,
    parameter int DIG_TICKS  = 4,
    parameter int GAP_W      = 32,
    parameter int N_PORTS    = 3,
    parameter int N_CNT      = 4,
    localparam int IDX_W     = $clog2(LIST_DEPTH),
    localparam int ENT_W     = CH_W + GAIN_W,
    localparam int REC_W     = IDX_W + ENT_W,
    localparam int TICK_W    = $clog2(SLOT_TICKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [CH_W-1:0]    wr_chan,
    input  logic [GAIN_W-1:0]  wr_gain,
    input  logic               run,
    input  logic [IDX_W-1:0]   last_idx,
    input  logic [GAP_W-1:0]   scan_gap,
    input  logic               per_slot_dig,
    input  logic               dig_only,
    input  logic               ext_mode,
    input  logic               ext_clk,
    input  logic [N_PORTS-1:0] port_en,
    input  logic [N_CNT-1:0]   cnt_en,
    output logic [CH_W-1:0]    mux_chan,
    output logic [GAIN_W-1:0]  mux_gain,
    output logic               adc_conv,
    output logic [N_PORTS-1:0] dig_strobe,
    output logic [N_CNT-1:0]   cnt_strobe,
    output logic               rec_valid,
    output logic [1:0]         rec_tag,
    output logic [REC_W-1:0]   rec_data,
    output logic               overrun
);
    seq_state_t        state;
    logic [IDX_W-1:0]  idx;
    logic [TICK_W-1:0] tick;
    logic [ENT_W-1:0]  entry;
    logic              ext_rise;
    logic              running;
    logic              ev_ana, ev_dig, ev_cnt, ev_sta;
    logic [REC_W-2:0]  scan_cnt;
    rec_tag_t          tag_sel;

    seq_list_ram #(.DEPTH(LIST_DEPTH), .ENT_W(ENT_W)) u_list (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data ({wr_chan, wr_gain}),
        .rd_addr (idx),
        .rd_data (entry)
    );

    seq_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_clk),
        .rise_o   (ext_rise)
    );

    seq_slot_ctrl #(
        .IDX_W(IDX_W), .GAP_W(GAP_W),
        .SLOT_TICKS(SLOT_TICKS), .DIG_TICKS(DIG_TICKS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ext_mode (ext_mode),
        .dig_only (dig_only),
        .last_idx (last_idx),
        .scan_gap (scan_gap),
        .ext_rise (ext_rise),
        .state    (state),
        .idx      (idx),
        .tick     (tick),
        .overrun  (overrun)
    );

    // Slot events, each on its own tick of the slot.
    assign running = (state == ST_RUN);
    assign ev_ana  = running && (tick == TICK_W'(0)) && !dig_only;
    assign ev_dig  = running && (tick == TICK_W'(1)) && (port_en != '0)
                     && (per_slot_dig || (idx == '0));
    assign ev_cnt  = running && (tick == TICK_W'(2)) && (cnt_en != '0) && (idx == '0);
    assign ev_sta  = running && (tick == TICK_W'(3)) && (idx == last_idx);

    // Drive selection and strobes toward the front end.
    assign mux_chan   = running ? entry[ENT_W-1:GAIN_W] : '0;
    assign mux_gain   = running ? entry[GAIN_W-1:0]     : '0;
    assign adc_conv   = ev_ana;
    assign dig_strobe = ev_dig ? port_en : '0;
    assign cnt_strobe = ev_cnt ? cnt_en  : '0;

    // Count completed scans since the last start.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) scan_cnt <= '0;
        else if (ev_sta)                scan_cnt <= scan_cnt + (REC_W-1)'(1);
    end

    // Pick the record tag and payload for this cycle.
    always_comb begin
        tag_sel  = TAG_ANA;
        rec_data = {idx, entry};
        if (ev_dig) begin
            tag_sel  = TAG_DIG;
            rec_data = REC_W'(idx);
        end else if (ev_cnt) begin
            tag_sel  = TAG_CNT;
            rec_data = REC_W'(idx);
        end else if (ev_sta) begin
            tag_sel  = TAG_STA;
            rec_data = {overrun, scan_cnt + (REC_W-1)'(1)};
        end
    end

    assign rec_valid = ev_ana | ev_dig | ev_cnt | ev_sta;
    assign rec_tag   = tag_sel;

    // Checker state: counters already sampled in the current scan.
    logic cnt_done;
    always_ff @(posedge clk) begin
        if (!rst_n || ev_sta || state == ST_IDLE) cnt_done <= 1'b0;
        else if (cnt_strobe != '0)                cnt_done <= 1'b1;
    end

    assert_one_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_ana, ev_dig, ev_cnt, ev_sta}));
    assert_conv_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_conv |=> !adc_conv);
    assert_cnt_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_strobe != '0) |-> !cnt_done);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !rec_valid);
endmodule

// File: tb/scan_sequencer_bench.sv
module scan_sequencer_bench;
    typedef struct packed {
        logic [8:0]  last;
        logic [15:0] gap;
        logic        ps;
        logic        dgo;
        logic [2:0]  pe;
        logic [3:0]  ce;
        logic [15:0] period;
        logic [9:0]  na;
        logic [9:0]  nd;
        logic [1:0]  nc;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{9'd0,  16'd0,   1'b0, 1'b0, 3'd7, 4'hF, 16'd48,  10'd1,  10'd1,  2'd1},
        '{9'd7,  16'd0,   1'b0, 1'b0, 3'd1, 4'h0, 16'd384, 10'd8,  10'd1,  2'd0},
        '{9'd7,  16'd0,   1'b1, 1'b0, 3'd3, 4'h1, 16'd384, 10'd8,  10'd8,  2'd1},
        '{9'd3,  16'd100, 1'b0, 1'b0, 3'd0, 4'h2, 16'd292, 10'd4,  10'd0,  2'd1},
        '{9'd15, 16'd0,   1'b1, 1'b1, 3'd7, 4'h0, 16'd64,  10'd0,  10'd16, 2'd0},
        '{9'd2,  16'd5,   1'b0, 1'b1, 3'd4, 4'h8, 16'd17,  10'd0,  10'd1,  2'd1},
        '{9'd1,  16'd1,   1'b1, 1'b0, 3'd0, 4'h0, 16'd97,  10'd2,  10'd0,  2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [3:0]  wr_chan = '0;
    logic [2:0]  wr_gain = '0;
    logic        run = 1'b0;
    logic [8:0]  last_idx = '0;
    logic [31:0] scan_gap = '0;
    logic        per_slot_dig = 1'b0;
    logic        dig_only = 1'b0;
    logic        ext_mode = 1'b0;
    logic        ext_clk = 1'b0;
    logic [2:0]  port_en = '0;
    logic [3:0]  cnt_en = '0;
    logic [3:0]  mux_chan;
    logic [2:0]  mux_gain;
    logic        adc_conv;
    logic [2:0]  dig_strobe;
    logic [3:0]  cnt_strobe;
    logic        rec_valid;
    logic [1:0]  rec_tag;
    logic [15:0] rec_data;
    logic        overrun;

    scan_sequencer u_scan_sequencer (.*);

    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ch_of(input int i);
        return 4'((i * 5 + 3) % 16);
    endfunction
    function automatic logic [2:0] gn_of(input int i);
        return 3'((i * 3 + 1) % 8);
    endfunction

    // Record monitor: per-scan windows closed by each status record.
    longint cyc = 0, last_sta = 0;
    int w_ana = 0, w_dig = 0, w_cnt = 0;
    int win_ana = 0, win_dig = 0, win_cnt = 0;
    longint win_period = 0;
    int sta_n = 0;
    logic [15:0] last_sta_data = '0;
    always @(negedge clk) begin
        cyc++;
        if (rec_valid) begin
            case (rec_tag)
                2'd0: w_ana++;
                2'd1: w_dig++;
                2'd2: w_cnt++;
                default: begin
                    win_ana = w_ana; win_dig = w_dig; win_cnt = w_cnt;
                    win_period = cyc - last_sta;
                    last_sta = cyc;
                    last_sta_data = rec_data;
                    w_ana = 0; w_dig = 0; w_cnt = 0;
                    sta_n++;
                end
            endcase
        end
    end

    task automatic wait_sta(input int target);
        for (int i = 0; i < 5000 && sta_n < target; i++) @(posedge clk);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        int quiet;
        // Reset state (R12)
        idle_cycles(4);
        chk(adc_conv == 1'b0 && rec_valid == 1'b0, "R12 conv/record in reset", {adc_conv, rec_valid}, 0);
        chk(dig_strobe == '0 && cnt_strobe == '0, "R12 strobes in reset", {dig_strobe, cnt_strobe}, 0);
        chk(overrun == 1'b0 && mux_chan == '0, "R12 overrun/mux in reset", {overrun, mux_chan}, 0);
        @(negedge clk) rst_n = 1'b1;
        idle_cycles(2);
        chk(rec_valid == 1'b0 && adc_conv == 1'b0, "R12 idle after reset", {rec_valid, adc_conv}, 0);

        // Load the list.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 9'(i); wr_chan = ch_of(i); wr_gain = gn_of(i);
        end
        @(negedge clk) wr_en = 1'b0;

        // Vector table walk (R3 R4 R5 R6 R7 R10)
        foreach (VECS[v]) begin
            @(negedge clk);
            last_idx = VECS[v].last; scan_gap = 32'(VECS[v].gap);
            per_slot_dig = VECS[v].ps; dig_only = VECS[v].dgo;
            port_en = VECS[v].pe; cnt_en = VECS[v].ce; ext_mode = 1'b0;
            @(negedge clk) run = 1'b1;
            base = sta_n;
            wait_sta(base + 1);
            chk(last_sta_data == 16'h0001, "R10 first status data", last_sta_data, 1);
            wait_sta(base + 2);
            chk(last_sta_data == 16'h0002, "R10 second status data", last_sta_data, 2);
            chk(win_period == longint'(VECS[v].period), "R3/R6/R7 scan period", win_period, VECS[v].period);
            chk(win_ana == int'(VECS[v].na), "R2/R7 analog records per scan", win_ana, VECS[v].na);
            chk(win_dig == int'(VECS[v].nd), "R4/R5 digital records per scan", win_dig, VECS[v].nd);
            chk(win_cnt == int'(VECS[v].nc), "R5 counter records per scan", win_cnt, VECS[v].nc);
            @(negedge clk) run = 1'b0;
            idle_cycles(800);
        end

        // Directed slot timing (R1 R2 R4 R5 R11)
        last_idx = 9'd3; scan_gap = 0; per_slot_dig = 1'b0; dig_only = 1'b0;
        port_en = 3'd5; cnt_en = 4'd3;
        @(negedge clk) run = 1'b1;
        for (int i = 0; i < 10 && !adc_conv; i++) @(negedge clk);
        chk(adc_conv == 1'b1, "R2 first convert strobe", adc_conv, 1);
        chk(mux_chan == ch_of(0) && mux_gain == gn_of(0), "R1 mux slot 0", {mux_chan, mux_gain}, {ch_of(0), gn_of(0)});
        chk(rec_valid && rec_tag == 2'd0 && rec_data == {9'd0, ch_of(0), gn_of(0)}, "R1 analog record slot 0",
            rec_data, {9'd0, ch_of(0), gn_of(0)});
        @(negedge clk);
        chk(dig_strobe == 3'd5 && rec_tag == 2'd1 && rec_data == 16'd0, "R4 digital sample slot 0", dig_strobe, 5);
        @(negedge clk);
        chk(cnt_strobe == 4'd3 && rec_tag == 2'd2, "R5 counter sample slot 0", cnt_strobe, 3);
        quiet = 0;
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            if (adc_conv) quiet++;
        end
        chk(quiet == 0, "R2 no convert inside slot", quiet, 0);
        @(negedge clk);
        chk(adc_conv == 1'b1, "R2 convert 48 cycles later", adc_conv, 1);
        chk(mux_chan == ch_of(1) && rec_data == {9'd1, ch_of(1), gn_of(1)}, "R1 analog record slot 1",
            rec_data, {9'd1, ch_of(1), gn_of(1)});
        @(negedge clk);
        chk(dig_strobe == 3'd0, "R4 no digital sample on slot 1", dig_strobe, 0);
        run = 1'b0;
        idle_cycles(98);
        chk(rec_valid && rec_tag == 2'd3 && rec_data == 16'h0001, "R11/R10 scan completes after stop", rec_data, 1);
        quiet = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (rec_valid || adc_conv) quiet++;
        end
        chk(quiet == 0, "R11 silent after stop", quiet, 0);

        // External pacing and overrun (R8 R9)
        last_idx = 9'd1; port_en = 3'd0; cnt_en = 4'd0; ext_mode = 1'b1;
        @(negedge clk) run = 1'b1;
        quiet = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rec_valid) quiet++;
        end
        chk(quiet == 0, "R8 no scan without edge", quiet, 0);
        base = sta_n;
        ext_clk = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(adc_conv == 1'b0, "R8 convert not before third edge", adc_conv, 0);
        @(negedge clk);
        chk(adc_conv == 1'b1, "R8 convert on third edge", adc_conv, 1);
        idle_cycles(10);
        ext_clk = 1'b0;
        idle_cycles(150);
        chk(sta_n == base + 1, "R8 exactly one scan per edge", sta_n - base, 1);
        chk(overrun == 1'b0, "R9 no overrun on clean edge", overrun, 0);
        ext_clk = 1'b1;
        idle_cycles(23);
        ext_clk = 1'b0;
        idle_cycles(5);
        ext_clk = 1'b1;
        idle_cycles(5);
        chk(overrun == 1'b1, "R9 overrun on edge mid-scan", overrun, 1);
        idle_cycles(150);
        chk(sta_n == base + 2, "R9 mid-scan edge ignored", sta_n - base, 2);
        chk(last_sta_data[15] == 1'b1, "R9/R10 overrun bit in status", last_sta_data[15], 1);
        ext_clk = 1'b0;
        run = 1'b0;
        idle_cycles(20);
        chk(overrun == 1'b1, "R9 overrun sticky while idle", overrun, 1);
        run = 1'b1;
        idle_cycles(3);
        chk(overrun == 1'b0, "R9 overrun cleared on restart", overrun, 0);
        run = 1'b0;
        idle_cycles(10);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule